// File: doc/BRIEF.md
# Power Control and Status Register

This block is the 8-bit power management register of a small microcontroller core. Software uses it to double the serial baud rate, to enable the power-fail interrupt and the watchdog reset, and to request the stop and idle low-power modes. Hardware uses it to record why the core last came out of reset and whether the supply is dropping. Reading the register clears the two event flags. Each reset kind clears or keeps each field by its own rule.

The bus side has a read strobe with combinational read data and a write strobe with write data. A timed-access input marks the cycles in which protected fields may be written. The event side takes a supply-low comparator level, a watchdog timeout pulse, an interrupt-serviced pulse and four reset-kind strobes: cold power-on, power-on with backup supply, watchdog reset and external reset. All of these are sampled on the rising clock edge. `rst_n` is the synchronous active-low reset. It puts every field at 0.

Top module: `pwr_ctl_reg`

## Requirements
- R1: After `rst_n` every field reads 0. The field positions in `rd_data` are: bit 7 baud double, bit 6 power-on flag, bit 5 power-fail flag, bit 4 watchdog-reset flag, bit 3 power-fail interrupt enable, bit 2 watchdog enable, bit 1 stop, bit 0 idle.
- R2: The power-fail flag sets in the cycle after `supply_low` is sampled high. It then stays set, whatever `supply_low` does, until a read. The read clears it in the cycle that follows.
- R3: A set event sampled in the same cycle as a read wins over the read. If `supply_low` is still high, the power-fail flag reads 1 again after a clearing read. A `wdog_expired` that coincides with a read leaves the watchdog-reset flag set.
- R4: `wdog_expired` sets the watchdog-reset flag, and a read clears it. Either power-on strobe clears both event flags. Watchdog and external reset strobes keep both event flags.
- R5: Either power-on strobe clears the power-on flag. Only a write inside the timed-access window changes it.
- R6: The watchdog enable clears only on a cold power-on strobe and keeps its value through every other reset kind. Only a write inside the timed-access window changes it.
- R7: The stop bit is written only inside the timed-access window. `stop_req` follows it from the cycle after the write. Any of the four reset strobes clears it.
- R8: The idle bit is freely writable. It clears on `irq_taken` (which wins over a same-cycle write) or on any reset strobe.
- R9: The baud-double bit and the power-fail interrupt enable are freely writable. Any reset strobe clears them.
- R10: Bus writes to the power-fail and watchdog-reset flags have no effect.
- R11: A write with `ta_open` low leaves the protected fields (power-on flag, watchdog enable, stop) unchanged. The freely writable fields of the same write still update.
- R12: `pfail_irq` is high exactly while the power-fail flag and its enable are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, all fields to 0 |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register value |
| ta_open | input | 1 | Timed-access window open |
| supply_low | input | 1 | Supply below warning threshold (level) |
| wdog_expired | input | 1 | Watchdog timeout pulse |
| irq_taken | input | 1 | Interrupt serviced pulse |
| rst_por_cold | input | 1 | Power-on reset strobe, no backup supply |
| rst_por_warm | input | 1 | Power-on reset strobe, backup supply present |
| rst_wdog | input | 1 | Watchdog reset strobe |
| rst_ext | input | 1 | External reset strobe |
| baud_x2 | output | 1 | Baud-double control |
| pfail_irq_en | output | 1 | Power-fail interrupt enable |
| wdog_en | output | 1 | Watchdog reset enable |
| stop_req | output | 1 | Stop mode request |
| idle_req | output | 1 | Idle mode request |
| pfail_irq | output | 1 | Power-fail interrupt request |

## Verification
The checker watches several rules on every cycle. It checks that the power-fail flag is set after a low-supply sample and holds until a read or power-on. It checks that a read without a coinciding timeout clears the watchdog-reset flag. It checks that stop cannot move outside the timed-access window or without a reset, that the watchdog enable stays put except on a cold power-on or a timed write, and that a serviced interrupt drops the idle request. Other rules need the bench's scenarios to show them: which fields each reset kind keeps, a write that mixes free and protected fields without the window, an event that wins over a clearing read, and the exact value the whole register reads back.

// File: rtl/pcon_pkg.sv
// Package: field positions, per-field access and clear masks, and the
// decoded reset-kind type shared by the power control register.
package pcon_pkg;

    localparam int REG_W = 8;

    localparam int F_BAUD = 7;
    localparam int F_PORF = 6;
    localparam int F_PFW  = 5;
    localparam int F_WDR  = 4;
    localparam int F_PFIE = 3;
    localparam int F_WDE  = 2;
    localparam int F_STOP = 1;
    localparam int F_IDLE = 0;

    localparam logic [REG_W-1:0] ONE = REG_W'(1);

    // Fields any write may change
    localparam logic [REG_W-1:0] OPEN_MASK = (ONE << F_BAUD) | (ONE << F_PFIE) | (ONE << F_IDLE);
    // Fields changed only inside the timed-access window
    localparam logic [REG_W-1:0] TA_MASK   = (ONE << F_PORF) | (ONE << F_WDE) | (ONE << F_STOP);
    // Fields cleared by any reset strobe
    localparam logic [REG_W-1:0] HW_CLR    = (ONE << F_BAUD) | (ONE << F_PFIE) | (ONE << F_STOP) | (ONE << F_IDLE);
    // Fields cleared by either power-on strobe
    localparam logic [REG_W-1:0] POR_CLR   = (ONE << F_PORF);
    // Fields cleared only by the cold power-on strobe
    localparam logic [REG_W-1:0] COLD_CLR  = (ONE << F_WDE);
    // Fields cleared when an interrupt is serviced
    localparam logic [REG_W-1:0] IRQ_CLR   = (ONE << F_IDLE);

    typedef struct packed {
        logic any_hw;   // any of the four reset strobes
        logic por_any;  // either power-on strobe
        logic por_cold; // power-on without backup supply
    } rst_kind_t;

endpackage

// File: rtl/pcon_rst_decode.sv
// Reset-kind decoder: folds the four reset strobes into the three clear
// classes used by the register fields. Assumes strobes are synchronous
// one-cycle pulses; purely combinational.
module pcon_rst_decode
    import pcon_pkg::*;
(
    input  logic      por_cold_i,
    input  logic      por_warm_i,
    input  logic      wdog_i,
    input  logic      ext_i,
    output rst_kind_t kind_o
);

    // Build the clear classes from the individual strobes
    always_comb begin
        kind_o.por_cold = por_cold_i;
        kind_o.por_any  = por_cold_i | por_warm_i;
        kind_o.any_hw   = por_cold_i | por_warm_i | wdog_i | ext_i;
    end

endmodule

// File: rtl/pcon_ctl_bit.sv
// One software-writable register field. Parameters choose its write
// access (free or timed) and which reset kinds and interrupt service
// clear it. Assumes rst_n is synchronous; a clear wins over a write.
module pcon_ctl_bit
    import pcon_pkg::*;
#(
    parameter bit OPEN     = 1'b0,
    parameter bit TIMED    = 1'b0,
    parameter bit CLR_HW   = 1'b0,
    parameter bit CLR_POR  = 1'b0,
    parameter bit CLR_COLD = 1'b0,
    parameter bit CLR_IRQ  = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_en,
    input  logic      wr_bit,
    input  logic      ta_open,
    input  logic      irq_taken,
    input  rst_kind_t kind,
    output logic      q
);

    logic clr_now;
    logic wr_ok;

    // Decide whether this field is cleared or written this cycle
    always_comb begin
        clr_now = (CLR_HW && kind.any_hw) || (CLR_POR && kind.por_any)
                || (CLR_COLD && kind.por_cold) || (CLR_IRQ && irq_taken);
        wr_ok   = wr_en && (OPEN || (TIMED && ta_open));
    end

    // Field storage: reset, clear, then write
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= 1'b0;
        else if (clr_now) q <= 1'b0;
        else if (wr_ok)   q <= wr_bit;
    end

endmodule

// File: rtl/pcon_event_flag.sv
// Hardware event flag cleared by reading. A set event wins over the
// read that would clear it, and a reset-class clear wins over both.
// Assumes the set input is sampled on every clock.
module pcon_event_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_clr_i,
    input  logic rst_clr_i,
    output logic q
);

    // Flag storage with clear-on-read and event priority
    always_ff @(posedge clk) begin
        if (!rst_n)         q <= 1'b0;
        else if (rst_clr_i) q <= 1'b0;
        else if (set_i)     q <= 1'b1;
        else if (rd_clr_i)  q <= 1'b0;
    end

endmodule

// File: rtl/pwr_ctl_reg.sv
// Power control and status register. Holds the writable control fields
// (one pcon_ctl_bit per field, chosen by the package masks) and two
// clear-on-read event flags. Read data is combinational from the stored
// fields; every update lands on the next rising edge.
module pwr_ctl_reg
    import pcon_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ta_open,
    input  logic             supply_low,
    input  logic             wdog_expired,
    input  logic             irq_taken,
    input  logic             rst_por_cold,
    input  logic             rst_por_warm,
    input  logic             rst_wdog,
    input  logic             rst_ext,
    output logic             baud_x2,
    output logic             pfail_irq_en,
    output logic             wdog_en,
    output logic             stop_req,
    output logic             idle_req,
    output logic             pfail_irq
);

    localparam logic [REG_W-1:0] WRITABLE = OPEN_MASK | TA_MASK;

    rst_kind_t        kind;
    logic [REG_W-1:0] ctl_q;
    logic             pfw_q;
    logic             wdr_q;

    pcon_rst_decode u_decode (
        .por_cold_i (rst_por_cold),
        .por_warm_i (rst_por_warm),
        .wdog_i     (rst_wdog),
        .ext_i      (rst_ext),
        .kind_o     (kind)
    );

    for (genvar i = 0; i < REG_W; i++) begin : g_field
        if (WRITABLE[i]) begin : g_rw
            pcon_ctl_bit #(
                .OPEN     (OPEN_MASK[i]),
                .TIMED    (TA_MASK[i]),
                .CLR_HW   (HW_CLR[i]),
                .CLR_POR  (POR_CLR[i]),
                .CLR_COLD (COLD_CLR[i]),
                .CLR_IRQ  (IRQ_CLR[i])
            ) u_bit (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en     (wr_en),
                .wr_bit    (wr_data[i]),
                .ta_open   (ta_open),
                .irq_taken (irq_taken),
                .kind      (kind),
                .q         (ctl_q[i])
            );
        end else begin : g_ro
            logic unused_wr_bit;
            assign unused_wr_bit = wr_data[i];
            assign ctl_q[i]      = 1'b0;
        end
    end

    pcon_event_flag u_pfw (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (supply_low),
        .rd_clr_i  (rd_en),
        .rst_clr_i (kind.por_any),
        .q         (pfw_q)
    );

    pcon_event_flag u_wdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (wdog_expired),
        .rd_clr_i  (rd_en),
        .rst_clr_i (kind.por_any),
        .q         (wdr_q)
    );

    // Merge the control fields and event flags into the read view
    always_comb begin
        rd_data = ctl_q | (REG_W'(pfw_q) << F_PFW) | (REG_W'(wdr_q) << F_WDR);
    end

    // Drive the control outputs and the interrupt request
    always_comb begin
        baud_x2      = ctl_q[F_BAUD];
        pfail_irq_en = ctl_q[F_PFIE];
        wdog_en      = ctl_q[F_WDE];
        stop_req     = ctl_q[F_STOP];
        idle_req     = ctl_q[F_IDLE];
        pfail_irq    = pfw_q & ctl_q[F_PFIE];
    end

endmodule

// File: rtl/pcon_chk.sv
// Checker for pwr_ctl_reg: cycle-by-cycle properties on ports only.
// Bound to every instance of the top module below.
module pcon_chk
    import pcon_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic             wr_en,
    input logic             ta_open,
    input logic             supply_low,
    input logic             wdog_expired,
    input logic             irq_taken,
    input logic             rst_por_cold,
    input logic             rst_por_warm,
    input logic             rst_wdog,
    input logic             rst_ext,
    input logic [REG_W-1:0] rd_data,
    input logic             stop_req,
    input logic             idle_req,
    input logic             wdog_en
);

    logic por_seen;
    logic hw_seen;

    // Group the reset strobes as the rules name them
    always_comb begin
        por_seen = rst_por_cold | rst_por_warm;
        hw_seen  = por_seen | rst_wdog | rst_ext;
    end

    AST_PFW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_low && !por_seen) |=> rd_data[F_PFW]); // R2

    AST_PFW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[F_PFW] && !rd_en && !por_seen) |=> rd_data[F_PFW]); // R2

    AST_WDR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wdog_expired) |=> !rd_data[F_WDR]); // R4

    AST_WDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_por_cold && !(wr_en && ta_open)) |=> $stable(wdog_en)); // R6

    AST_STOP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ta_open && !hw_seen) |=> $stable(stop_req)); // R11

    AST_STOP_HW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_seen |=> !stop_req); // R7

    AST_IDLE_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> !idle_req); // R8

endmodule

bind pwr_ctl_reg pcon_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_en        (rd_en),
    .wr_en        (wr_en),
    .ta_open      (ta_open),
    .supply_low   (supply_low),
    .wdog_expired (wdog_expired),
    .irq_taken    (irq_taken),
    .rst_por_cold (rst_por_cold),
    .rst_por_warm (rst_por_warm),
    .rst_wdog     (rst_wdog),
    .rst_ext      (rst_ext),
    .rd_data      (rd_data),
    .stop_req     (stop_req),
    .idle_req     (idle_req),
    .wdog_en      (wdog_en)
);

// File: tb/tb_pwr_ctl_reg.sv
// Scoreboard bench: read tasks queue the expected register value, and a
// monitor pops and compares it in the middle of the read cycle.
module tb_pwr_ctl_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0, wr_en = 1'b0, ta_open = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       supply_low = 1'b0, wdog_expired = 1'b0, irq_taken = 1'b0;
    logic       rst_por_cold = 1'b0, rst_por_warm = 1'b0, rst_wdog = 1'b0, rst_ext = 1'b0;
    logic       baud_x2, pfail_irq_en, wdog_en, stop_req, idle_req, pfail_irq;

    int compared = 0;
    int mismatched = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    pwr_ctl_reg dut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ta_open(ta_open), .supply_low(supply_low),
        .wdog_expired(wdog_expired), .irq_taken(irq_taken),
        .rst_por_cold(rst_por_cold), .rst_por_warm(rst_por_warm),
        .rst_wdog(rst_wdog), .rst_ext(rst_ext), .baud_x2(baud_x2),
        .pfail_irq_en(pfail_irq_en), .wdog_en(wdog_en), .stop_req(stop_req),
        .idle_req(idle_req), .pfail_irq(pfail_irq)
    );

    // Monitor: compare read data against the queued expectation
    always @(negedge clk) begin
        item_t it;
        if (rst_n && rd_en) begin
            compared++;
            if (sb.size() == 0) begin
                mismatched++;
                $display("FAIL %s: read with empty queue, actual %02h", "R1", rd_data);
            end else begin
                it = sb.pop_front();
                if (rd_data !== it.exp) begin
                    mismatched++;
                    $display("FAIL %s: actual %02h expected %02h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic do_read(input logic [7:0] exp, input string tag);
        sb.push_back('{exp, tag});
        rd_en = 1'b1;
        step();
        rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d, input logic ta);
        wr_en = 1'b1; wr_data = d; ta_open = ta;
        step();
        wr_en = 1'b0; ta_open = 1'b0;
    endtask

    task automatic check_port(input logic act, input logic exp, input string tag);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (sb.size() != 0) begin
            mismatched++;
            $display("FAIL R1: %0d reads never seen, actual 0 expected %0d", sb.size(), sb.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog: a hung run is counted as a failure
    initial begin
        repeat (20000) @(posedge clk);
        mismatched++;
        $display("FAIL R1: watchdog expired, actual hung expected done");
        finish_run();
    end

    // Stimulus
    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        do_read(8'h00, "R1 reset value");

        // Free write of all ones without the window
        do_write(8'hFF, 1'b0);
        do_read(8'h89, "R11 untimed write keeps protected fields");
        check_port(stop_req, 1'b0, "R11 stop stays low");

        // Timed write of all ones
        do_write(8'hFF, 1'b1);
        check_port(stop_req, 1'b1, "R7 stop request follows write");
        check_port(idle_req, 1'b1, "R8 idle request set");
        check_port(baud_x2, 1'b1, "R9 baud double set");
        do_read(8'hCF, "R10 flags ignore writes");

        // Interrupt service drops idle
        irq_taken = 1'b1; step(); irq_taken = 1'b0;
        check_port(idle_req, 1'b0, "R8 idle cleared by interrupt");
        do_read(8'hCE, "R8 register after interrupt");

        // Power-fail flag with interrupt enabled
        supply_low = 1'b1; step(); supply_low = 1'b0;
        step(); step();
        check_port(pfail_irq, 1'b1, "R12 interrupt with enable set");
        do_read(8'hEE, "R2 flag held after supply recovers");
        do_read(8'hCE, "R2 flag cleared by read");

        // Interrupt enable off
        do_write(8'h80, 1'b0);
        supply_low = 1'b1; step(); supply_low = 1'b0;
        check_port(pfail_irq, 1'b0, "R12 no interrupt with enable clear");
        do_read(8'hE6, "R12 flag set with enable clear");
        do_read(8'hC6, "R2 cleared again");

        // Supply still low across reads
        supply_low = 1'b1; step();
        do_read(8'hE6, "R3 first read while low");
        do_read(8'hE6, "R3 flag re-set while still low");
        supply_low = 1'b0;
        do_read(8'hE6, "R3 last set before recovery");
        do_read(8'hC6, "R3 cleared after recovery");

        // Watchdog flag
        wdog_expired = 1'b1; step(); wdog_expired = 1'b0;
        do_read(8'hD6, "R4 watchdog flag set");
        do_read(8'hC6, "R4 watchdog flag cleared by read");
        wdog_expired = 1'b1; step(); wdog_expired = 1'b0;
        do_write(8'hC6, 1'b1);
        do_read(8'hD6, "R10 write of 0 to flag ignored");
        do_read(8'hC6, "R10 read clears");
        wdog_expired = 1'b1;
        do_read(8'hC6, "R3 read during timeout");
        wdog_expired = 1'b0;
        do_read(8'hD6, "R3 timeout wins over read");
        do_read(8'hC6, "R4 cleared");

        // External reset
        do_write(8'h89, 1'b0);
        wdog_expired = 1'b1; step(); wdog_expired = 1'b0;
        check_port(idle_req, 1'b1, "R8 idle set by free write");
        rst_ext = 1'b1; step(); rst_ext = 1'b0;
        check_port(stop_req, 1'b0, "R7 stop cleared by external reset");
        check_port(idle_req, 1'b0, "R8 idle cleared by external reset");
        check_port(baud_x2, 1'b0, "R9 baud cleared by external reset");
        check_port(pfail_irq_en, 1'b0, "R9 enable cleared by external reset");
        check_port(wdog_en, 1'b1, "R6 watchdog enable kept");
        do_read(8'h54, "R4 flags kept through external reset");
        do_read(8'h44, "R4 cleared after read");

        // Watchdog reset
        rst_wdog = 1'b1; step(); rst_wdog = 1'b0;
        do_read(8'h44, "R6 fields kept through watchdog reset");

        // Warm power-on
        wdog_expired = 1'b1; supply_low = 1'b1; step();
        wdog_expired = 1'b0; supply_low = 1'b0;
        rst_por_warm = 1'b1; step(); rst_por_warm = 1'b0;
        check_port(wdog_en, 1'b1, "R6 enable kept through warm power-on");
        do_read(8'h04, "R5 warm power-on clears flags");

        // Power-on flag writes
        do_write(8'h44, 1'b1);
        do_read(8'h44, "R5 timed write sets power-on flag");
        do_write(8'h00, 1'b0);
        do_read(8'h44, "R5 untimed write leaves power-on flag");

        // Cold power-on
        rst_por_cold = 1'b1; step(); rst_por_cold = 1'b0;
        check_port(wdog_en, 1'b0, "R6 enable cleared by cold power-on");
        do_read(8'h00, "R6 cold power-on clears all");

        step();
        finish_run();
    end

endmodule